// File: doc/BRIEF.md
# ADPCM Speech Decoder

This block turns a stream of 4-bit adaptive differential codes back into 8-bit mu-law companded speech samples. It takes one code per sample strobe, at a nominal 8 kHz rate, while the decode enable is high. The decode enable is kept low whenever the matching encoder is busy, so the two never run at once. Each accepted code is expanded by an inverse adaptive quantizer into a signed difference. The difference is added to a running 16-bit linear prediction, and the saturated sum becomes both the reconstructed sample and the prediction for the next code. The quantizer step then adapts through a step index.

The reconstructed linear sample goes through a mu-law compressor to give the output byte. That byte is registered together with a one-cycle valid flag. Step sizes and index adaptation follow fixed rules that an encoder must share exactly. If they did not, the two predictors would drift apart.

Top module: `adpcm_decoder`

## Requirements
- R1: A synchronous reset (`rst` high at a clock edge) clears the predictor to 0 and the step index to 0. From the next cycle it drives `pcm_o` to 0xFF, the mu-law byte for zero, and holds `pcm_vld_o` low.
- R2: A code is consumed only at a rising edge where `dec_en` and `smp_stb` are both high. After that edge `pcm_o` carries the new byte and `pcm_vld_o` is high for exactly one cycle. At any other edge `pcm_o` and the predictor hold their values and `pcm_vld_o` is low.
- R3: The step size for index i (0 to 79) is (8 + (i mod 8)) shifted left by floor(i / 8). Index 0 therefore gives 8 and index 79 gives 7680.
- R4: The code is a sign bit (bit 3, set means subtract) over a 3-bit magnitude. The difference is step>>3, plus step when bit 2 is set, plus step>>1 when bit 1 is set, plus step>>2 when bit 0 is set. From reset, code 4 yields prediction 9 and byte 0xFE.
- R5: The new prediction is the old prediction plus or minus the difference, saturated to the range -32768 to 32767. Positive saturation gives byte 0x80 and negative saturation gives byte 0x00.
- R6: After each decoded code the step index changes by -1 for magnitudes 0 to 3, and by +2, +4, +6 or +8 for magnitudes 4, 5, 6 and 7. The result is clamped to the range 0 to 79.
- R7: Mu-law compression works as follows. Take the magnitude of the sample, clip it at 32635 and add 132. The exponent e is the position of the leading one among bits 14..7, minus 7, or 0 if none of them is set. The mantissa is bits e+6..e+3. The output is the bitwise inverse of {sign, e[2:0], mantissa[3:0]}, where sign is 1 for a negative sample.

Top module ports follow.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| dec_en | input | 1 | Decode enable, kept low while encoding |
| smp_stb | input | 1 | Sample strobe, one cycle per sample period |
| code_i | input | 4 | ADPCM code: bit 3 sign, bits 2..0 magnitude |
| pcm_o | output | 8 | Reconstructed mu-law companded byte |
| pcm_vld_o | output | 1 | One-cycle pulse when `pcm_o` holds a new byte |

## Verification
The block holds its state in the prediction and the step index. A wrong prediction shows in the very next output byte, because that byte is the compressed prediction. A wrong step index stays hidden until a later code uses the step, and then it shows as a byte that differs from the reference decoder. The error then persists, because both state values are recurrent. The bench therefore runs long random code streams against a reference model, and runs saturation sequences that push both the prediction and the index to their clamps.

// File: rtl/adpcm_dec_pkg.sv
package adpcm_dec_pkg;

    localparam int CODE_W  = 4;
    localparam int LIN_W   = 16;
    localparam int PCM_W   = 8;
    localparam int IDX_W   = 7;
    localparam int STEP_W  = 16;

    localparam logic [PCM_W-1:0] MULAW_ZERO = 8'hFF;

    typedef logic signed [LIN_W-1:0] lin_t;

    typedef struct packed {
        lin_t             pred;
        logic [IDX_W-1:0] idx;
        logic [PCM_W-1:0] pcm;
        logic             vld;
    } dec_state_t;

endpackage

// File: rtl/adpcm_step_gen.sv
module adpcm_step_gen #(
    parameter int IDX_W     = 7,
    parameter int STEP_W    = 16,
    parameter int FRAC_W    = 3,
    parameter int MANT_BASE = 8
) (
    input  logic [IDX_W-1:0]  idx_i,
    output logic [STEP_W-1:0] step_o
);
    localparam int OCT_W = IDX_W - FRAC_W;

    logic [STEP_W-1:0] mant;
    logic [OCT_W-1:0]  octave;

    always_comb begin
        mant   = STEP_W'(MANT_BASE) + STEP_W'(idx_i[FRAC_W-1:0]);
        octave = idx_i[IDX_W-1:FRAC_W];
        step_o = mant << octave;
    end
endmodule

// File: rtl/adpcm_invq.sv
module adpcm_invq #(
    parameter int CODE_W = 4,
    parameter int LIN_W  = 16,
    parameter int IDX_W  = 7,
    parameter int STEP_W = 16,
    parameter int NSTEPS = 80
) (
    input  logic [CODE_W-1:0]       code_i,
    input  logic [STEP_W-1:0]       step_i,
    input  logic signed [LIN_W-1:0] pred_i,
    input  logic [IDX_W-1:0]        idx_i,
    output logic signed [LIN_W-1:0] pred_o,
    output logic [IDX_W-1:0]        idx_o
);
    localparam int ACC_W = STEP_W + 2;
    localparam int SUM_W = ((LIN_W > ACC_W) ? LIN_W : ACC_W) + 2;
    localparam int IXS_W = IDX_W + 2;
    localparam logic signed [SUM_W-1:0] LIN_MAX = SUM_W'((64'sd1 <<< (LIN_W - 1)) - 64'sd1);
    localparam logic signed [SUM_W-1:0] LIN_MIN = -LIN_MAX - SUM_W'(1);
    localparam logic signed [IXS_W-1:0] IDX_TOP = IXS_W'(NSTEPS - 1);

    logic [ACC_W-1:0]              diff;
    logic signed [SUM_W-1:0]       pred_ext;
    logic signed [SUM_W-1:0]       diff_ext;
    logic signed [SUM_W-1:0]       sum;
    logic signed [IXS_W-1:0]       adj;
    logic signed [IXS_W-1:0]       idx_sum;

    // difference from step and magnitude bits
    always_comb begin
        diff = ACC_W'(step_i >> 3);
        if (code_i[2]) diff = diff + ACC_W'(step_i);
        if (code_i[1]) diff = diff + ACC_W'(step_i >> 1);
        if (code_i[0]) diff = diff + ACC_W'(step_i >> 2);
    end

    // prediction update with saturation
    always_comb begin
        pred_ext = SUM_W'(pred_i);
        diff_ext = signed'({{(SUM_W - ACC_W){1'b0}}, diff});
        sum      = code_i[CODE_W-1] ? (pred_ext - diff_ext) : (pred_ext + diff_ext);
        if (sum > LIN_MAX)      pred_o = LIN_MAX[LIN_W-1:0];
        else if (sum < LIN_MIN) pred_o = LIN_MIN[LIN_W-1:0];
        else                    pred_o = sum[LIN_W-1:0];
    end

    // step index adaptation with clamp
    always_comb begin
        unique case (code_i[2:0])
            3'd4:    adj = IXS_W'(2);
            3'd5:    adj = IXS_W'(4);
            3'd6:    adj = IXS_W'(6);
            3'd7:    adj = IXS_W'(8);
            default: adj = -IXS_W'(1);
        endcase
        idx_sum = signed'({2'b00, idx_i}) + adj;
        if (idx_sum < 0)            idx_o = '0;
        else if (idx_sum > IDX_TOP) idx_o = IDX_TOP[IDX_W-1:0];
        else                        idx_o = idx_sum[IDX_W-1:0];
    end
endmodule

// File: rtl/adpcm_mulaw_cmp.sv
module adpcm_mulaw_cmp #(
    parameter int LIN_W  = 16,
    parameter int PCM_W  = 8,
    parameter int EXP_W  = 3,
    parameter int MANT_W = 4,
    parameter int BIAS   = 132,
    parameter int CLIP   = 32635
) (
    input  logic signed [LIN_W-1:0] lin_i,
    output logic [PCM_W-1:0]        byte_o
);
    localparam int NSEG  = 1 << EXP_W;
    localparam int LOW   = MANT_W + EXP_W;   // lowest bit of the segment search
    localparam int ABS_W = LIN_W + 1;
    localparam int SH_W  = EXP_W + 2;

    logic                    neg;
    logic signed [ABS_W-1:0] wide;
    logic [ABS_W-1:0]        absval;
    logic [LIN_W-1:0]        mag;
    logic [EXP_W-1:0]        seg;
    logic [SH_W-1:0]         sh;
    logic [LIN_W-1:0]        shifted;

    always_comb begin
        neg    = lin_i[LIN_W-1];
        wide   = ABS_W'(lin_i);
        absval = neg ? unsigned'(-wide) : unsigned'(wide);
        if (absval > ABS_W'(CLIP)) absval = ABS_W'(CLIP);
        mag = LIN_W'(absval) + LIN_W'(BIAS);
        seg = '0;
        for (int i = 0; i < NSEG; i++) begin
            if (mag[i + LOW]) seg = EXP_W'(i);
        end
        sh      = SH_W'(seg) + SH_W'(EXP_W);
        shifted = mag >> sh;
        byte_o  = ~{neg, seg, shifted[MANT_W-1:0]};
    end
endmodule

// File: rtl/adpcm_decoder.sv
module adpcm_decoder
    import adpcm_dec_pkg::*;
#(
    parameter int NSTEPS    = 80,
    parameter int MANT_BASE = 8,
    parameter int BIAS      = 132,
    parameter int CLIP      = 32635
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              dec_en,
    input  logic              smp_stb,
    input  logic [CODE_W-1:0] code_i,
    output logic [PCM_W-1:0]  pcm_o,
    output logic              pcm_vld_o
);
    dec_state_t       st_q, st_d;
    logic [STEP_W-1:0] step;
    lin_t             pred_nx;
    logic [IDX_W-1:0] idx_nx;
    logic [PCM_W-1:0] byte_nx;
    logic             fire;

    adpcm_step_gen #(
        .IDX_W(IDX_W), .STEP_W(STEP_W), .FRAC_W(3), .MANT_BASE(MANT_BASE)
    ) u_step (
        .idx_i(st_q.idx), .step_o(step)
    );

    adpcm_invq #(
        .CODE_W(CODE_W), .LIN_W(LIN_W), .IDX_W(IDX_W), .STEP_W(STEP_W), .NSTEPS(NSTEPS)
    ) u_invq (
        .code_i(code_i), .step_i(step), .pred_i(st_q.pred), .idx_i(st_q.idx),
        .pred_o(pred_nx), .idx_o(idx_nx)
    );

    adpcm_mulaw_cmp #(
        .LIN_W(LIN_W), .PCM_W(PCM_W), .EXP_W(3), .MANT_W(4), .BIAS(BIAS), .CLIP(CLIP)
    ) u_cmp (
        .lin_i(pred_nx), .byte_o(byte_nx)
    );

    assign fire = dec_en && smp_stb;

    always_comb begin
        st_d     = st_q;
        st_d.vld = 1'b0;
        if (fire) begin
            st_d.pred = pred_nx;
            st_d.idx  = idx_nx;
            st_d.pcm  = byte_nx;
            st_d.vld  = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q.pred <= '0;
            st_q.idx  <= '0;
            st_q.pcm  <= MULAW_ZERO;
            st_q.vld  <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assign pcm_o     = st_q.pcm;
    assign pcm_vld_o = st_q.vld;
endmodule

// File: rtl/adpcm_decoder_chk.sv
module adpcm_decoder_chk #(
    parameter int NSTEPS = 80
) (
    input logic               clk,
    input logic               rst,
    input logic               dec_en,
    input logic               smp_stb,
    input logic [7:0]         pcm_o,
    input logic               pcm_vld_o,
    input logic signed [15:0] pred_q,
    input logic [6:0]         idx_q
);
    AST_RESET_OUT: assert property (@(posedge clk)
        rst |=> (pcm_o == 8'hFF && !pcm_vld_o)); // R1

    AST_VLD_CAUSE: assert property (@(posedge clk) disable iff (rst)
        pcm_vld_o |-> $past(dec_en && smp_stb)); // R2

    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst)
        !(dec_en && smp_stb) |=> ($stable(pcm_o) && $stable(pred_q) && !pcm_vld_o)); // R2

    AST_IDX_RANGE: assert property (@(posedge clk) disable iff (rst)
        int'(idx_q) < NSTEPS); // R6

    AST_IDX_STEP: assert property (@(posedge clk) disable iff (rst)
        pcm_vld_o |-> (int'(idx_q) <= int'($past(idx_q)) + 8 && int'(idx_q) + 1 >= int'($past(idx_q)))); // R6

    AST_ZERO_BYTE: assert property (@(posedge clk) disable iff (rst)
        (pred_q == 16'sd0) |-> (pcm_o == 8'hFF)); // R7

    AST_SIGN_BIT: assert property (@(posedge clk) disable iff (rst)
        pcm_vld_o |-> (pcm_o[7] == !pred_q[15])); // R7
endmodule

bind adpcm_decoder adpcm_decoder_chk #(.NSTEPS(NSTEPS)) u_chk (
    .clk(clk), .rst(rst), .dec_en(dec_en), .smp_stb(smp_stb),
    .pcm_o(pcm_o), .pcm_vld_o(pcm_vld_o),
    .pred_q(st_q.pred), .idx_q(st_q.idx)
);

// File: tb/adpcm_decoder_tb.sv
`timescale 1ns/1ps
module adpcm_decoder_tb;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       dec_en = 1'b0;
    logic       smp_stb = 1'b0;
    logic [3:0] code = 4'd0;
    logic [7:0] pcm;
    logic       vld;

    int n_chk = 0;
    int n_err = 0;
    int m_pred = 0;
    int m_idx = 0;
    int m_pcm = 255;

    always #2.5 clk = ~clk;

    adpcm_decoder u_dut (
        .clk(clk), .rst(rst), .dec_en(dec_en), .smp_stb(smp_stb),
        .code_i(code), .pcm_o(pcm), .pcm_vld_o(vld)
    );

    function automatic int step_of(int i);
        return (8 + (i % 8)) << (i / 8);
    endfunction

    function automatic int mulaw_of(int x);
        int s, a, e, m;
        s = (x < 0) ? 1 : 0;
        a = (x < 0) ? -x : x;
        if (a > 32635) a = 32635;
        a = a + 132;
        e = 0;
        for (int i = 0; i < 8; i++) if (((a >> (i + 7)) & 1) != 0) e = i;
        m = (a >> (e + 3)) & 15;
        return (~((s << 7) | (e << 4) | m)) & 255;
    endfunction

    task automatic model_apply(int c);
        int st, d;
        st = step_of(m_idx);
        d  = st >> 3;
        if ((c & 4) != 0) d += st;
        if ((c & 2) != 0) d += st >> 1;
        if ((c & 1) != 0) d += st >> 2;
        m_pred = ((c & 8) != 0) ? m_pred - d : m_pred + d;
        if (m_pred > 32767)  m_pred = 32767;
        if (m_pred < -32768) m_pred = -32768;
        case (c & 7)
            4: m_idx += 2;
            5: m_idx += 4;
            6: m_idx += 6;
            7: m_idx += 8;
            default: m_idx -= 1;
        endcase
        if (m_idx < 0)  m_idx = 0;
        if (m_idx > 79) m_idx = 79;
        m_pcm = mulaw_of(m_pred);
    endtask

    task automatic chk(string req, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_err++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic send(int c, string req);
        @(negedge clk);
        dec_en = 1'b1; smp_stb = 1'b1; code = 4'(c);
        model_apply(c);
        @(negedge clk);
        smp_stb = 1'b0;
        chk(req, int'(pcm), m_pcm);
        chk(req, int'(vld), 1);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1; dec_en = 1'b0; smp_stb = 1'b0;
        @(negedge clk);
        @(negedge clk);
        rst = 1'b0;
        m_pred = 0; m_idx = 0; m_pcm = 255;
        chk("R1 reset byte", int'(pcm), 255);
        chk("R1 reset valid", int'(vld), 0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_err++;
        $display("FAIL watchdog expired");
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end

    initial begin
        int prev_fire;
        void'($urandom(32'd20240611));
        do_reset();

        // R3 R4: first code from reset uses step 8
        send(4, "R4 code4 from reset");
        chk("R4 code4 byte", int'(pcm), 8'hFE);
        @(negedge clk);
        chk("R2 valid one cycle", int'(vld), 0);

        do_reset();
        send(7, "R3 step index 0 full magnitude");
        send(1, "R3 step after +8");
        send(9, "R4 negative sign");

        // R2: strobe without enable, enable without strobe
        @(negedge clk);
        dec_en = 1'b0; smp_stb = 1'b1; code = 4'd7;
        repeat (3) begin
            @(negedge clk);
            chk("R2 strobe ignored without enable", int'(pcm), m_pcm);
            chk("R2 no valid without enable", int'(vld), 0);
        end
        dec_en = 1'b1; smp_stb = 1'b0;
        repeat (3) begin
            @(negedge clk);
            chk("R2 enable ignored without strobe", int'(pcm), m_pcm);
            chk("R2 no valid without strobe", int'(vld), 0);
        end

        // R5 R6: push to positive saturation and top index
        for (int k = 0; k < 40; k++) send(7, "R6 index climb");
        chk("R5 positive saturation byte", int'(pcm), 8'h80);
        send(3, "R6 index clamp top");
        for (int k = 0; k < 40; k++) send(15, "R5 negative drive");
        chk("R5 negative saturation byte", int'(pcm), 8'h00);
        for (int k = 0; k < 100; k++) send(0, "R6 index clamp bottom");
        send(12, "R6 after bottom clamp");

        // R7: sweep of small magnitudes around zero
        do_reset();
        for (int k = 0; k < 30; k++) send((k % 2 == 0) ? 1 : 9, "R7 small values");

        // random stream mixed with idle cycles
        do_reset();
        prev_fire = 0;
        for (int k = 0; k < 4000; k++) begin
            int c;
            @(negedge clk);
            if (k > 0) begin
                chk("R7 random byte", int'(pcm), m_pcm);
                chk("R2 random valid", int'(vld), prev_fire);
            end
            dec_en  = ($urandom % 8) != 0;
            smp_stb = ($urandom % 3) == 0;
            c = int'($urandom % 16);
            if (($urandom % 5) == 0) c = (c & 8) | 7;
            code = 4'(c);
            prev_fire = (dec_en && smp_stb) ? 1 : 0;
            if (prev_fire != 0) model_apply(c);
        end
        @(negedge clk);
        chk("R7 random last byte", int'(pcm), m_pcm);
        smp_stb = 1'b0;

        // R1: reset in mid stream
        do_reset();
        send(5, "R1 restart from zero");

        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end
endmodule